// File: doc/BRIEF.md
# Per-Bit Write Eye Centring Sequencer

This block trains the write timing of a data byte one bit at a time. Each data lane has its own delay setting. The block steps all lanes together through every delay tap. At each tap it asks for a write burst carrying a fixed toggling pattern and then a read burst of the same location. It compares every returned beat against what was written and records, for each lane, whether that tap passed.

When the last tap has been tried, each lane is parked in the middle of its longest contiguous run of passing taps. A lane that never passed is marked as failed and left at tap zero. The command port uses a valid/ready handshake. The protocol engine behind it issues the real DRAM commands and returns the read beats on a separate valid-qualified bus. The tap outputs drive the physical delay lines directly.

Top module: `wc_write_centering`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` and `cmd_valid_o` are 0, every lane's tap on `tap_o` is 0, and `fail_o` is all zeros.
- R2: A `start_i` pulse from idle or from the finished state begins a sweep of exactly NTAPS write/read command pairs. Each write comes before its read, and no new command is raised until the read data of the previous pair has arrived. A raised command stays raised, with the same kind, until `cmd_ready_i` accepts it. No command is raised while `done_o` is 1.
- R3: During a sweep, every lane's tap field `tap_o[i*TAPW +: TAPW]` equals the index of the current pair, counting from 0. The index rises by one per pair.
- R4: The write burst on `wr_data_o` holds BURST beats, with beat k in bits `[k*NBITS +: NBITS]`. Bit i of beat k is 1 when i+k is even and 0 otherwise, so beats alternate 0x55 and 0xAA for an 8-bit lane group.
- R5: A lane passes a tap only if all BURST read beats for that tap match the written pattern on that lane. A mismatch in any single beat, including the last one, fails the tap.
- R6: When finished, each passing lane's tap is floor((first+last)/2) over its longest contiguous passing run. Among runs of equal length, the one that starts at the lowest tap wins.
- R7: When finished, a lane with no passing tap shows 1 on its `fail_o` bit and 0 on its tap field. Lanes that passed show 0 on `fail_o`.
- R8: `done_o` rises after the last tap has been evaluated. It then holds, together with the final taps and `fail_o`, until the next `start_i`. A `start_i` pulse during a sweep is ignored.
- R9: Lanes are evaluated independently: one lane's pass/fail history has no effect on another lane's final tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse to begin a training sweep |
| done_o | output | 1 | High while final results are presented |
| cmd_valid_o | output | 1 | Command request valid |
| cmd_write_o | output | 1 | 1 for a write burst, 0 for a read burst |
| cmd_ready_i | input | 1 | Command accepted this cycle |
| wr_data_o | output | BURST*NBITS | Write burst pattern, all beats in parallel |
| rd_valid_i | input | 1 | One read beat present |
| rd_data_i | input | NBITS | Read beat data |
| tap_o | output | NBITS*TAPW | Per-lane delay tap, lane i in bits [i*TAPW +: TAPW] |
| fail_o | output | NBITS | Per-lane no-eye flag, valid while done_o is 1 |

## Verification
If a lane's run tracker holds a wrong start or length, that lane's final tap shows the error as soon as `done_o` rises. A tracker that fails to reset between sweeps leaves stale results that a second sweep with different eyes exposes. A miscounted beat or tap counter changes the number of command pairs or the taps shown at each write. Those are visible at the very first write after the fault. A comparator that skips a beat shows up when the bench corrupts only the final read beat of a tap.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_COLLECT,
    ST_EVAL,
    ST_DONE
  } wc_state_e;
endpackage

// File: rtl/wc_seq.sv
module wc_seq
  import wc_pkg::*;
#(
  parameter int NTAPS = 32,
  parameter int BURST = 4,
  localparam int TAPW = $clog2(NTAPS),
  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cmd_ready_i,
  input  logic            rd_valid_i,
  output logic            cmd_valid_o,
  output logic            cmd_write_o,
  output logic            clr_o,
  output logic            err_clr_o,
  output logic            beat_en_o,
  output logic [BW-1:0]   beat_o,
  output logic            upd_o,
  output logic            done_o,
  output logic [TAPW-1:0] tap_o
);
  localparam logic [TAPW-1:0] LAST_TAP = TAPW'(NTAPS - 1);
  localparam logic [BW-1:0]   LAST_BEAT = BW'(BURST - 1);

  wc_state_e state_q, state_d;
  logic [TAPW-1:0] tap_q, tap_d;
  logic [BW-1:0]   beat_q, beat_d;

  always_comb begin
    state_d     = state_q;
    tap_d       = tap_q;
    beat_d      = beat_q;
    cmd_valid_o = 1'b0;
    cmd_write_o = 1'b0;
    clr_o       = 1'b0;
    err_clr_o   = 1'b0;
    beat_en_o   = 1'b0;
    upd_o       = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        done_o = (state_q == ST_DONE);
        if (start_i) begin
          clr_o   = 1'b1;
          tap_d   = '0;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        cmd_valid_o = 1'b1;
        cmd_write_o = 1'b1;
        if (cmd_ready_i) state_d = ST_READ;
      end
      ST_READ: begin
        cmd_valid_o = 1'b1;
        if (cmd_ready_i) begin
          err_clr_o = 1'b1;
          beat_d    = '0;
          state_d   = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (rd_valid_i) begin
          beat_en_o = 1'b1;
          beat_d    = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        upd_o = 1'b1;
        if (tap_q == LAST_TAP) begin
          state_d = ST_DONE;
        end else begin
          tap_d   = tap_q + 1'b1;
          state_d = ST_WRITE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      beat_q  <= beat_d;
    end
  end

  assign beat_o = beat_q;
  assign tap_o  = tap_q;
endmodule

// File: rtl/wc_cmp.sv
module wc_cmp #(
  parameter int NBITS = 8,
  parameter int BURST = 4,
  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               err_clr_i,
  input  logic               beat_en_i,
  input  logic [BW-1:0]      beat_i,
  input  logic [NBITS-1:0]   rd_data_i,
  output logic [BURST*NBITS-1:0] wr_data_o,
  output logic [NBITS-1:0]   pass_o
);
  logic [NBITS-1:0] err_q, err_d;
  logic [NBITS-1:0] even_pat, odd_pat, exp_beat;

  for (genvar i = 0; i < NBITS; i++) begin : g_pat
    assign even_pat[i] = ((i % 2) == 0);
    assign odd_pat[i]  = ((i % 2) != 0);
  end

  for (genvar k = 0; k < BURST; k++) begin : g_beat
    assign wr_data_o[k*NBITS +: NBITS] = ((k % 2) == 0) ? even_pat : odd_pat;
  end

  assign exp_beat = beat_i[0] ? odd_pat : even_pat;

  always_comb begin
    err_d = err_q;
    if (err_clr_i)      err_d = '0;
    else if (beat_en_i) err_d = err_q | (rd_data_i ^ exp_beat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= err_d;
  end

  assign pass_o = ~err_q;
endmodule

// File: rtl/wc_bit_window.sv
module wc_bit_window #(
  parameter int TAPW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            upd_i,
  input  logic            pass_i,
  input  logic [TAPW-1:0] tap_i,
  output logic [TAPW-1:0] centre_o,
  output logic            none_o
);
  logic [TAPW:0]   cur_len_q, cur_len_d, best_len_q, best_len_d;
  logic [TAPW-1:0] cur_st_q, cur_st_d, best_st_q, best_st_d;
  logic [TAPW:0]   run_len, half_len;
  logic [TAPW-1:0] run_st;

  assign run_len = cur_len_q + 1'b1;
  assign run_st  = (cur_len_q == '0) ? tap_i : cur_st_q;

  always_comb begin
    cur_len_d  = cur_len_q;
    cur_st_d   = cur_st_q;
    best_len_d = best_len_q;
    best_st_d  = best_st_q;
    if (clr_i) begin
      cur_len_d  = '0;
      cur_st_d   = '0;
      best_len_d = '0;
      best_st_d  = '0;
    end else if (upd_i) begin
      if (pass_i) begin
        cur_len_d = run_len;
        cur_st_d  = run_st;
        if (run_len > best_len_q) begin
          best_len_d = run_len;
          best_st_d  = run_st;
        end
      end else begin
        cur_len_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_len_q  <= '0;
      cur_st_q   <= '0;
      best_len_q <= '0;
      best_st_q  <= '0;
    end else begin
      cur_len_q  <= cur_len_d;
      cur_st_q   <= cur_st_d;
      best_len_q <= best_len_d;
      best_st_q  <= best_st_d;
    end
  end

  assign none_o   = (best_len_q == '0);
  assign half_len = (best_len_q - 1'b1) >> 1;
  assign centre_o = none_o ? '0 : best_st_q + half_len[TAPW-1:0];
endmodule

// File: rtl/wc_write_centering.sv
module wc_write_centering #(
  parameter int NBITS = 8,
  parameter int NTAPS = 32,
  parameter int BURST = 4,
  localparam int TAPW = $clog2(NTAPS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   done_o,
  output logic                   cmd_valid_o,
  output logic                   cmd_write_o,
  input  logic                   cmd_ready_i,
  output logic [BURST*NBITS-1:0] wr_data_o,
  input  logic                   rd_valid_i,
  input  logic [NBITS-1:0]       rd_data_i,
  output logic [NBITS*TAPW-1:0]  tap_o,
  output logic [NBITS-1:0]       fail_o
);
  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;

  logic            clr, err_clr, beat_en, upd, done;
  logic [BW-1:0]   beat;
  logic [TAPW-1:0] sweep_tap;
  logic [NBITS-1:0] pass, none;

  wc_seq #(.NTAPS(NTAPS), .BURST(BURST)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .cmd_ready_i(cmd_ready_i), .rd_valid_i(rd_valid_i),
    .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o),
    .clr_o(clr), .err_clr_o(err_clr), .beat_en_o(beat_en), .beat_o(beat),
    .upd_o(upd), .done_o(done), .tap_o(sweep_tap)
  );

  wc_cmp #(.NBITS(NBITS), .BURST(BURST)) cmp_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_clr_i(err_clr),
    .beat_en_i(beat_en), .beat_i(beat), .rd_data_i(rd_data_i),
    .wr_data_o(wr_data_o), .pass_o(pass)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_lane
    logic [TAPW-1:0] centre;
    wc_bit_window #(.TAPW(TAPW)) win_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .upd_i(upd),
      .pass_i(pass[i]), .tap_i(sweep_tap),
      .centre_o(centre), .none_o(none[i])
    );
    assign tap_o[i*TAPW +: TAPW] = done ? centre : sweep_tap;
  end

  assign done_o = done;
  assign fail_o = done ? none : '0;
endmodule

// File: rtl/wc_write_centering_chk.sv
module wc_write_centering_chk #(
  parameter int NBITS = 8,
  parameter int NTAPS = 32,
  parameter int BURST = 4,
  localparam int TAPW = $clog2(NTAPS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   done_o,
  input logic                   cmd_valid_o,
  input logic                   cmd_write_o,
  input logic                   cmd_ready_i,
  input logic [BURST*NBITS-1:0] wr_data_o,
  input logic                   rd_valid_i,
  input logic [NBITS-1:0]       rd_data_i,
  input logic [NBITS*TAPW-1:0]  tap_o,
  input logic [NBITS-1:0]       fail_o
);
  a_r2_no_cmd_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o);

  a_r2_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_write_o)));

  a_r8_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(tap_o) && $stable(fail_o)));

  a_r1_fail_clear_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (fail_o == '0));

  for (genvar i = 0; i < NBITS; i++) begin : g_lane_chk
    a_r7_fail_tap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && fail_o[i]) |-> (tap_o[i*TAPW +: TAPW] == '0));
    a_r3_uniform_taps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> (tap_o[i*TAPW +: TAPW] == tap_o[TAPW-1:0]));
  end
endmodule

bind wc_write_centering wc_write_centering_chk #(
  .NBITS(NBITS), .NTAPS(NTAPS), .BURST(BURST)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o), .cmd_ready_i(cmd_ready_i),
  .wr_data_o(wr_data_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
  .tap_o(tap_o), .fail_o(fail_o)
);

// File: tb/wc_write_centering_tb.sv
module wc_write_centering_tb_top;
  localparam int NBITS = 8;
  localparam int NTAPS = 32;
  localparam int BURST = 4;
  localparam int TAPW  = $clog2(NTAPS);
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;

  // Per-lane passing-tap masks (bit t set = tap t passes), one row per vector.
  localparam logic [31:0] MASKS [NVEC][NBITS] = '{
    '{32'h0000FF00, 32'h000FFFF0, 32'hFFFFFFFF, 32'h00000001,
      32'h80000000, 32'h00000000, 32'h0FF00000, 32'h000003F0},
    '{32'h00F000F0, 32'h0FF0000F, 32'hAAAAAAAA, 32'h7FFFFFFE,
      32'hC0000003, 32'h0000FFFF, 32'hFFFF0000, 32'h00000000},
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000,
      32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000},
    '{32'h00FFFF00, 32'h00FFFF00, 32'h00FFFF00, 32'h00FFFF00,
      32'h00FFFF00, 32'h00FFFF00, 32'h00FFFF00, 32'h00FFFF00}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, cmd_ready_i, rd_valid_i;
  logic [NBITS-1:0] rd_data_i;
  logic done_o, cmd_valid_o, cmd_write_o;
  logic [BURST*NBITS-1:0] wr_data_o;
  logic [NBITS*TAPW-1:0] tap_o;
  logic [NBITS-1:0] fail_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wc_write_centering #(.NBITS(NBITS), .NTAPS(NTAPS), .BURST(BURST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .done_o(done_o),
    .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o), .cmd_ready_i(cmd_ready_i),
    .wr_data_o(wr_data_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .tap_o(tap_o), .fail_o(fail_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic pat_bit(input int lane, input int beat);
    return ((lane + beat) % 2) == 0;
  endfunction

  function automatic int exp_tap(input logic [31:0] m);
    int bs = 0, bl = 0, cs = 0, cl = 0;
    for (int t = 0; t < NTAPS; t++) begin
      if (m[t]) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    return (bl == 0) ? 0 : bs + (bl - 1) / 2;
  endfunction

  task automatic run_sweep(input int vi, input bit poke_start,
                           output int nwr, output int nrd);
    int wtap [NBITS];
    bit poked = 0;
    nwr = 0; nrd = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) begin
      if (cmd_valid_o && cmd_write_o) begin
        for (int i = 0; i < NBITS; i++) begin
          wtap[i] = int'(tap_o[i*TAPW +: TAPW]);
          check($sformatf("R3 lane %0d tap at pair %0d", i, nwr), wtap[i], nwr);
        end
        for (int k = 0; k < BURST; k++)
          for (int i = 0; i < NBITS; i++)
            check("R4 write pattern bit", wr_data_o[k*NBITS+i], pat_bit(i, k));
        nwr++;
        @(negedge clk);
        start_i = 1'b0;
      end else if (cmd_valid_o && !cmd_write_o) begin
        nrd++;
        @(negedge clk);
        if (poke_start && !poked && nwr == 10) begin start_i = 1'b1; poked = 1; end
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < BURST; k++) begin
          rd_valid_i = 1'b1;
          for (int i = 0; i < NBITS; i++)
            rd_data_i[i] = pat_bit(i, k) ^
              ((k == BURST - 1) && !MASKS[vi][i][wtap[i]]);
          @(negedge clk);
        end
        rd_valid_i = 1'b0;
        rd_data_i  = '0;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int nwr, nrd;
    rst_n = 1'b0; start_i = 1'b0; cmd_ready_i = 1'b1;
    rd_valid_i = 1'b0; rd_data_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", done_o, 0);
    check("R1 cmd_valid", cmd_valid_o, 0);
    check("R1 taps", tap_o, 0);
    check("R1 fail", fail_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle cmd_valid after release", cmd_valid_o, 0);
    check("R1 idle taps after release", tap_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_sweep(v, v == 3, nwr, nrd);
      // R2 pair count, R8 ignored start during vector 3
      check($sformatf("R2 R8 write count vec %0d", v), nwr, NTAPS);
      check($sformatf("R2 read count vec %0d", v), nrd, NTAPS);
      check("R8 done raised", done_o, 1);
      for (int i = 0; i < NBITS; i++) begin
        // R5 R6 R9 per-lane centre, R7 no-eye flag
        check($sformatf("R6 R9 vec %0d lane %0d tap", v, i),
              tap_o[i*TAPW +: TAPW], exp_tap(MASKS[v][i]));
        check($sformatf("R7 vec %0d lane %0d fail", v, i),
              fail_o[i], MASKS[v][i] == 0);
      end
      repeat (3) @(negedge clk);
      check("R8 done held", done_o, 1);
      check("R2 no command while done", cmd_valid_o, 0);
      check($sformatf("R8 taps held vec %0d lane 1", v),
            tap_o[TAPW +: TAPW], exp_tap(MASKS[v][1]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule